// File: doc/BRIEF.md
# Complementary Dead-Time Pair Generator

This block turns the pulse-width waveform of the first channel of a channel pair into two complementary drive signals for a half-bridge. After every edge of the source waveform it inserts a dead interval. During that interval both outputs are held low, so the upper and lower switches are never driven at the same time. The interval length is an 8-bit count of ticks of the pair's prescaled clock, not of system clock cycles. Each pair has its own enable bit, tick strobe and interval, and no pair affects another.

When a pair's enable bit is clear, each of its two outputs passes its own channel waveform through unchanged. When the bit is set, the second channel's raw waveform is ignored. The second output becomes the delayed complement of the first channel, and the first output becomes its delayed copy. Output inversion and pin enables sit downstream of this block.

Top module: `dtpair_gen`

## Requirements
- R1: With `pair_en[p]` = 0, `chan_out[2p]` equals `chan_in[2p]` and `chan_out[2p+1]` equals `chan_in[2p+1]` in the same cycle, for every input pattern.
- R2: With `pair_en[p]` = 1, `chan_in[2p+1]` has no effect on either output of pair p.
- R3: When `chan_in[2p]` rises while the pair is enabled, `chan_out[2p+1]` goes low in the same cycle. `chan_out[2p]` goes high right after the clock edge that registers the N-th tick, where N is the interval. A tick is a rising clock edge with `tick_en[p]` = 1 while `chan_in[2p]` is high. This holds up to the largest interval, 255.
- R4: When `chan_in[2p]` falls while the pair is enabled, `chan_out[2p]` goes low in the same cycle. `chan_out[2p+1]` goes high after N ticks counted while `chan_in[2p]` is low.
- R5: While a pair is enabled, its two outputs are never high together.
- R6: The delay advances only on ticks. Without `tick_en[p]`, a delayed output stays low however many clock cycles pass.
- R7: If the source level lasts fewer than N ticks, the delayed output stays low for that whole level. Every edge restarts the count from zero.
- R8: With an interval of 0 on an enabled pair, `chan_out[2p]` equals `chan_in[2p]` and `chan_out[2p+1]` equals its inverse, with no gap.
- R9: Pair p uses only `chan_in[2p+1:2p]`, `tick_en[p]`, `pair_en[p]` and `dead_len[DT_W*p +: DT_W]`. Another pair's tick, enable or interval has no effect on it.
- R10: A synchronous active-low reset clears every delay count. After reset, with the pair enabled, a nonzero interval and `chan_in[2p]` low, both outputs of the pair are low until N ticks have been counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_in | input | 2*NUM_PAIRS | Raw channel waveforms; bit 2p is the first channel of pair p, bit 2p+1 the second |
| tick_en | input | NUM_PAIRS | One-cycle strobe per pair marking a prescaled clock tick |
| pair_en | input | NUM_PAIRS | Complementary mode enable per pair |
| dead_len | input | NUM_PAIRS*DT_W | Dead interval in ticks, DT_W bits per pair |
| chan_out | output | 2*NUM_PAIRS | Drive outputs, same bit mapping as chan_in |

## Verification
The bench builds the block with NUM_PAIRS = 2 and DT_W = 8. Two pairs make it possible to check that one pair's tick, enable and interval do not reach the other. Eight-bit intervals allow the largest delay of 255 ticks, where the count runs one step short of its width. Ticks are given as isolated strobes, which separates tick counting from cycle counting, and also as a continuous strobe for the longest interval.

// File: rtl/dtp_pkg.sv
// Shared types for the dead-time pair generator.
package dtp_pkg;
    // State of one delay leg: waiting out the dead interval, or passing.
    typedef enum logic {
        LEG_WAIT = 1'b0,
        LEG_PASS = 1'b1
    } leg_state_e;
endpackage

// File: rtl/dtp_delay_leg.sv
// Rising-edge delay leg.
// What it does: the output follows src, but a rise of src is delayed until
// `interval` ticks have been seen while src stays high. A fall is immediate.
// Assumes: tick is a one-cycle strobe synchronous to clk; interval may change
// at any time and is compared live (>=), so the count can never overshoot.
module dtp_delay_leg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         src,
    input  logic         tick,
    input  logic [W-1:0] interval,
    output logic         out
);
    import dtp_pkg::*;

    localparam int CW = W + 1;

    leg_state_e    state;
    logic [W-1:0]  cnt;
    logic [CW-1:0] cnt_next;
    logic          zero_len;

    // Next count value, one bit wider so the comparison cannot wrap.
    assign cnt_next = {1'b0, cnt} + {{W{1'b0}}, 1'b1};
    assign zero_len = (interval == '0);

    // Count ticks while src is high; restart whenever src is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LEG_WAIT;
            cnt   <= '0;
        end else if (!src) begin
            state <= LEG_WAIT;
            cnt   <= '0;
        end else if (state == LEG_WAIT && tick) begin
            cnt <= cnt_next[W-1:0];
            if (cnt_next >= {1'b0, interval}) begin
                state <= LEG_PASS;
            end
        end
    end

    // Output drops with src at once; rises only once the wait is over.
    assign out = src & ((state == LEG_PASS) | zero_len);
endmodule

// File: rtl/dtp_pair.sv
// One channel pair.
// What it does: in complementary mode it derives a delayed copy and a delayed
// complement of the first channel; otherwise it passes both channels through.
// Assumes: both legs always track the first channel, so switching modes never
// leaves a stale count behind.
module dtp_pair #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raw_a,
    input  logic            raw_b,
    input  logic            tick,
    input  logic            enable,
    input  logic [DT_W-1:0] dead_len,
    output logic            drv_a,
    output logic            drv_b
);
    logic hi_leg;
    logic lo_leg;

    // Leg for the primary output: delays the rise of the source.
    dtp_delay_leg #(.W(DT_W)) u_hi (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (raw_a),
        .tick     (tick),
        .interval (dead_len),
        .out      (hi_leg)
    );

    // Leg for the complement: delays the rise of the inverted source.
    dtp_delay_leg #(.W(DT_W)) u_lo (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (~raw_a),
        .tick     (tick),
        .interval (dead_len),
        .out      (lo_leg)
    );

    // Select complementary drive or plain pass-through.
    always_comb begin
        if (enable) begin
            drv_a = hi_leg;
            drv_b = lo_leg;
        end else begin
            drv_a = raw_a;
            drv_b = raw_b;
        end
    end
endmodule

// File: rtl/dtpair_gen.sv
// Dead-time pair generator top.
// What it does: instantiates one independent pair stage per channel pair.
// Assumes: bit 2p / 2p+1 of the channel buses belong to pair p, and the
// interval of pair p sits at dead_len[DT_W*p +: DT_W].
module dtpair_gen #(
    parameter int NUM_PAIRS = 2,
    parameter int DT_W      = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [2*NUM_PAIRS-1:0]    chan_in,
    input  logic [NUM_PAIRS-1:0]      tick_en,
    input  logic [NUM_PAIRS-1:0]      pair_en,
    input  logic [NUM_PAIRS*DT_W-1:0] dead_len,
    output logic [2*NUM_PAIRS-1:0]    chan_out
);
    // One pair stage per channel pair; no sharing between pairs (R9).
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        dtp_pair #(.DT_W(DT_W)) u_pair (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_a    (chan_in[2*p]),
            .raw_b    (chan_in[2*p+1]),
            .tick     (tick_en[p]),
            .enable   (pair_en[p]),
            .dead_len (dead_len[DT_W*p +: DT_W]),
            .drv_a    (chan_out[2*p]),
            .drv_b    (chan_out[2*p+1])
        );
    end
endmodule

// File: rtl/dtpair_gen_chk.sv
// Port-level checker for dtpair_gen, attached by bind below.
// What it does: checks pass-through, overlap, immediate falls, the zero-length
// case and that delayed rises only follow a tick.
module dtpair_gen_chk #(
    parameter int NUM_PAIRS = 2,
    parameter int DT_W      = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [2*NUM_PAIRS-1:0]    chan_in,
    input logic [NUM_PAIRS-1:0]      tick_en,
    input logic [NUM_PAIRS-1:0]      pair_en,
    input logic [NUM_PAIRS*DT_W-1:0] dead_len,
    input logic [2*NUM_PAIRS-1:0]    chan_out
);
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_chk
        // R1: disabled pair passes both channels through.
        p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
            !pair_en[p] |-> chan_out[2*p+1:2*p] == chan_in[2*p+1:2*p]);

        // R5: never both outputs high in complementary mode.
        p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
            pair_en[p] |-> !(chan_out[2*p] && chan_out[2*p+1]));

        // R4: primary output is low whenever the source is low.
        p_fall_now_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (pair_en[p] && !chan_in[2*p]) |-> !chan_out[2*p]);

        // R3: complement output is low whenever the source is high.
        p_comp_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (pair_en[p] && chan_in[2*p]) |-> !chan_out[2*p+1]);

        // R8: zero interval gives an exact complement.
        p_zero_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (pair_en[p] && dead_len[DT_W*p +: DT_W] == '0)
                |-> (chan_out[2*p] == chan_in[2*p]
                     && chan_out[2*p+1] == !chan_in[2*p]));

        // R6: without a tick the delayed primary output cannot rise.
        p_tick_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (pair_en[p] && $past(pair_en[p]) && chan_in[2*p]
             && $past(chan_in[2*p]) && !$past(tick_en[p])
             && dead_len[DT_W*p +: DT_W] != '0
             && $stable(dead_len[DT_W*p +: DT_W]))
                |-> !$rose(chan_out[2*p]));
    end
endmodule

bind dtpair_gen dtpair_gen_chk #(
    .NUM_PAIRS (NUM_PAIRS),
    .DT_W      (DT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .chan_in  (chan_in),
    .tick_en  (tick_en),
    .pair_en  (pair_en),
    .dead_len (dead_len),
    .chan_out (chan_out)
);

// File: tb/dtpair_gen_bench.sv
// Directed bench for dtpair_gen: one task per scenario, each checking itself.
module dtpair_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NP         = 2;
    localparam int DW         = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [2*NP-1:0]   chan_in;
    logic [NP-1:0]     tick_en;
    logic [NP-1:0]     pair_en;
    logic [NP*DW-1:0]  dead_len;
    logic [2*NP-1:0]   chan_out;

    int  n_chk  = 0;
    int  n_bad  = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dtpair_gen #(.NUM_PAIRS(NP), .DT_W(DW)) u_dtpair_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .chan_in  (chan_in),
        .tick_en  (tick_en),
        .pair_en  (pair_en),
        .dead_len (dead_len),
        .chan_out (chan_out)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk4(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Advance to the next falling edge, then let combinational paths settle.
    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // One tick strobe on pair p, seen by exactly one rising edge.
    task automatic pulse_tick(input int p);
        @(negedge clk);
        tick_en[p] = 1'b1;
        @(negedge clk);
        tick_en[p] = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        rst_n    = 1'b0;
        chan_in  = '0;
        tick_en  = '0;
        pair_en  = 2'b11;
        dead_len = 16'h0303;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        chk4("R10 reset outputs low", chan_out, 4'b0000);
        step();
        chk4("R10 still low without ticks", chan_out, 4'b0000);
    endtask

    task automatic t_pass();
        pair_en = 2'b00;
        for (int v = 0; v < 16; v++) begin
            @(negedge clk);
            chan_in = v[3:0];
            #1;
            chk4("R1 passthrough", chan_out, v[3:0]);
        end
    endtask

    task automatic t_rise_fall();
        @(negedge clk);
        pair_en  = 2'b01;
        dead_len = {8'd0, 8'd3};
        chan_in  = 4'b0000;
        #1;
        chk("R4 complement low before ticks", chan_out[1], 1'b0);
        pulse_tick(0);
        pulse_tick(0);
        chk("R4 complement low after 2 ticks", chan_out[1], 1'b0);
        pulse_tick(0);
        chk("R4 complement high after 3 ticks", chan_out[1], 1'b1);
        // Rising edge of source: complement drops at once.
        @(negedge clk);
        chan_in[0] = 1'b1;
        #1;
        chk("R3 complement falls immediately", chan_out[1], 1'b0);
        chk("R3 primary still low", chan_out[0], 1'b0);
        // Second raw channel is ignored in complementary mode.
        chan_in[1] = 1'b1;
        #1;
        chk("R2 raw_b high ignored", chan_out[1], 1'b0);
        repeat (20) step();
        chk("R6 no ticks keeps primary low", chan_out[0], 1'b0);
        chan_in[1] = 1'b0;
        pulse_tick(0);
        pulse_tick(0);
        chk("R3 primary low after 2 ticks", chan_out[0], 1'b0);
        pulse_tick(0);
        chk("R3 primary high after 3 ticks", chan_out[0], 1'b1);
        chk("R3 complement stays low", chan_out[1], 1'b0);
        // Falling edge: primary drops at once, complement waits.
        @(negedge clk);
        chan_in[0] = 1'b0;
        #1;
        chk("R4 primary falls immediately", chan_out[0], 1'b0);
        chk("R4 complement low in dead time", chan_out[1], 1'b0);
        pulse_tick(0);
        pulse_tick(0);
        chk("R4 complement low after 2 ticks", chan_out[1], 1'b0);
        pulse_tick(0);
        chk("R4 complement high after 3 ticks", chan_out[1], 1'b1);
    endtask

    task automatic t_short();
        @(negedge clk);
        dead_len = {8'd0, 8'd4};
        chan_in  = 4'b0001;
        pulse_tick(0);
        pulse_tick(0);
        chk("R7 primary low mid pulse", chan_out[0], 1'b0);
        @(negedge clk);
        chan_in[0] = 1'b0;
        #1;
        chk("R7 short pulse never reached output", chan_out[0], 1'b0);
        @(negedge clk);
        chan_in[0] = 1'b1;
        pulse_tick(0);
        pulse_tick(0);
        pulse_tick(0);
        chk("R7 count restarted, low after 3", chan_out[0], 1'b0);
        pulse_tick(0);
        chk("R7 high after 4 fresh ticks", chan_out[0], 1'b1);
    endtask

    task automatic t_zero();
        logic [4:0] pat = 5'b10110;
        @(negedge clk);
        dead_len = '0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chan_in[0] = pat[i];
            #1;
            chk("R8 primary equals source", chan_out[0], pat[i]);
            chk("R8 complement is inverse", chan_out[1], ~pat[i]);
        end
    endtask

    task automatic t_max();
        @(negedge clk);
        chan_in[0] = 1'b0;
        dead_len   = {8'd0, 8'd255};
        tick_en[0] = 1'b1;
        @(negedge clk);
        chan_in[0] = 1'b1;
        repeat (254) @(negedge clk);
        #1;
        chk("R3 max interval low after 254", chan_out[0], 1'b0);
        @(negedge clk);
        #1;
        chk("R3 max interval high after 255", chan_out[0], 1'b1);
        tick_en[0] = 1'b0;
    endtask

    task automatic t_indep();
        @(negedge clk);
        pair_en  = 2'b01;
        dead_len = {8'd0, 8'd2};
        chan_in  = 4'b0000;
        @(negedge clk);
        chan_in = 4'b1001;
        #1;
        chk("R9 disabled pair 1 passes bits 3:2", chan_out[3:2] == 2'b10, 1'b1);
        pulse_tick(0);
        pulse_tick(0);
        chk("R9 pair 0 delayed primary high", chan_out[0], 1'b1);
        @(negedge clk);
        pair_en  = 2'b10;
        dead_len = {8'd1, 8'd0};
        chan_in  = 4'b0000;
        @(negedge clk);
        chan_in = 4'b0110;
        #1;
        chk("R9 disabled pair 0 passes bits 1:0", chan_out[1:0] == 2'b10, 1'b1);
        chk("R9 pair 1 primary waits", chan_out[2], 1'b0);
        pulse_tick(0);
        chk("R9 pair 0 tick does not reach pair 1", chan_out[2], 1'b0);
        pulse_tick(1);
        chk("R9 pair 1 own tick releases primary", chan_out[2], 1'b1);
    endtask

    initial begin
        t_reset();
        t_pass();
        t_rise_fall();
        t_short();
        t_zero();
        t_max();
        t_indep();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog: an expired run is counted as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule